// File: doc/BRIEF.md
# Virtual Link Traffic Shaper and Scheduler

This block paces and merges the transmit traffic of several virtual links onto one output stream. Each link presents the head of its own frame queue as a ready flag and a length. A per-link regulator holds a gap timer, counted in microsecond ticks. The timer lets the link release at most one frame per programmed bandwidth gap. The regulator also rejects any frame longer than that link's programmed maximum length.

A round-robin multiplexer picks one eligible link at a time. When it picks a link, the block pulses that link's pop line so that the upstream queue advances. One cycle later it raises a frame-start strobe together with the chosen link number. No further frame is started until the transmit side reports that the current frame is done.

An oversize frame at the head of a queue is popped and discarded at once. Each discard is counted in a saturating per-link error counter, and the discard leaves the link's gap timer untouched. Because the pointer moves past the last link served, the wait of any eligible link is limited to the grants of the other links.

Top module: `vl_shaper`

## Requirements
- R1: After reset, frm_start is 0, every drop_cnt field is 0, and every link counts as having its gap elapsed, so the first ready frame within its limit is popped in the first cycle it is presented.
- R2: Bag code c (3 bits, field c of vl_bag_code at bits [3v+2:3v] for link v) sets a gap of N = TICKS_PER_MS * 2^c ticks, which is 1 ms to 128 ms. After a link is granted, it is not granted again until N us_tick pulses have been sampled at clock edges strictly after the granting edge.
- R3: The gap timer restarts at the grant edge, not at the end of the frame. With us_tick high every cycle and tx_done high, one link granted back to back shows starts exactly N+1 cycles apart. A long transmission does not lengthen the next gap.
- R4: A frame whose frm_len field (bits [LEN_W*v +: LEN_W]) exceeds the vl_lmax field of its link is never granted. In the same cycle it is popped through frm_pop.
- R5: A discarded oversize frame leaves the link's gap timer unchanged, so a following valid frame on that link is granted at once if the gap had already elapsed.
- R6: Among eligible links, the one granted is the first found when scanning upward, with wrap, from the link after the previously granted one. The scan starts at link 0 after reset.
- R7: A link that is not eligible is skipped in the same cycle. Whenever the block is idle and any link is eligible, a grant is made in that cycle.
- R8: A grant pulses frm_pop for that link in the grant cycle. In the next cycle frm_start is 1 for one cycle and tx_vl holds the link number. No further grant is made until tx_done is sampled high.
- R9: While a link stays eligible, at most NUM_VL-1 grants to other links occur before it is granted.
- R10: Each discard increments the link's drop_cnt field (bits [ERR_W*v +: ERR_W]) by one. The field saturates at 2^ERR_W-1.
- R11: tx_done has no effect while no frame is in flight. frm_start is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond, drives the gap timers |
| frm_rdy | input | NUM_VL | Queue of link v holds a frame |
| frm_len | input | NUM_VL*LEN_W | Length of the head frame, per link |
| vl_lmax | input | NUM_VL*LEN_W | Maximum allowed frame length, per link |
| vl_bag_code | input | NUM_VL*3 | Gap code c, gap = 2^c ms, per link |
| tx_done | input | 1 | Transmit side finished the current frame |
| frm_pop | output | NUM_VL | Advance the queue of link v (grant or discard) |
| frm_start | output | 1 | One-cycle strobe, a frame starts |
| tx_vl | output | ID_W | Link number of the frame started |
| drop_cnt | output | NUM_VL*ERR_W | Saturating discard counters, per link |

## Verification
The bench builds the block with NUM_VL=4, TICKS_PER_MS=4, LEN_W=11 and ERR_W=3. It programs the links with bag codes 0, 1, 2 and 7. A four-tick millisecond makes even the 128 ms gap only 512 cycles long, so the longest spacing is measured exactly within a short run. The 3-bit error counter reaches saturation after seven discards. Four links are enough for the pointer to wrap and to skip an idle link between two eligible ones.

// File: rtl/vl_shaper_pkg.sv
package vl_shaper_pkg;

  localparam int BAG_CODE_W = 3;
  localparam int BAG_MAX_MS = 128;

  // Gap length in ticks for a power-of-two code in milliseconds.
  function automatic int unsigned bag_ticks(input logic [BAG_CODE_W-1:0] code,
                                            input int unsigned ticks_per_ms);
    return ticks_per_ms << code;
  endfunction

  // Link after idx, wrapping at n.
  function automatic int unsigned next_slot(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/vl_regulator.sv
module vl_regulator
  import vl_shaper_pkg::*;
#(
  parameter int LEN_W        = 11,
  parameter int TICKS_PER_MS = 1000,
  parameter int ERR_W        = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  us_tick,
  input  logic                  rdy,
  input  logic [LEN_W-1:0]      len,
  input  logic [LEN_W-1:0]      lmax,
  input  logic [BAG_CODE_W-1:0] bag_code,
  input  logic                  take,
  output logic                  elig,
  output logic                  drop,
  output logic [ERR_W-1:0]      err_cnt
);

  localparam int TMR_W = $clog2(TICKS_PER_MS * BAG_MAX_MS + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [TMR_W-1:0] gap_q;
  logic             oversize;
  logic             gap_open;

  assign oversize = len > lmax;
  assign gap_open = (gap_q == '0);
  assign drop     = rdy & oversize;
  assign elig     = rdy & ~oversize & gap_open;

  // Gap timer: loaded at the grant edge, counts ticks down to zero.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (take) begin
      gap_q <= TMR_W'(bag_ticks(bag_code, TICKS_PER_MS));
    end else if (us_tick && !gap_open) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  // Saturating discard counter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (drop && err_cnt != ERR_MAX) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  a_r2_take_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> gap_open);

  a_r4_take_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rdy && len <= lmax));

  a_r5_drop_keeps_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && gap_open) |=> gap_open);

  a_r10_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (err_cnt == (($past(err_cnt) == ERR_MAX) ? ERR_MAX : $past(err_cnt) + 1'b1)));

endmodule

// File: rtl/vl_rr_arb.sv
module vl_rr_arb
  import vl_shaper_pkg::*;
#(
  parameter int NUM_VL = 4,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NUM_VL-1:0] req,
  output logic [NUM_VL-1:0] take,
  output logic [ID_W-1:0]   pick_id
);

  localparam int WAIT_W = $clog2(NUM_VL + 1) + 1;

  logic [ID_W-1:0] ptr_q;
  logic            found;

  // Scan upward from the pointer, wrapping, first requester wins.
  always_comb begin
    int idx;
    found   = 1'b0;
    pick_id = '0;
    idx     = 0;
    for (int k = 0; k < NUM_VL; k++) begin
      idx = (int'(ptr_q) + k) % NUM_VL;
      if (!found && req[idx]) begin
        found   = 1'b1;
        pick_id = ID_W'(idx);
      end
    end
    take = '0;
    if (en && found) take[pick_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (en && found) begin
      ptr_q <= ID_W'(next_slot(int'(pick_id), NUM_VL));
    end
  end

  // Per-link count of grants to others while it waits (checker state).
  for (genvar v = 0; v < NUM_VL; v++) begin : g_wait
    logic [WAIT_W-1:0] wait_q;
    always_ff @(posedge clk) begin
      if (!rst_n || take[v] || !req[v]) begin
        wait_q <= '0;
      end else if (|take && wait_q != '1) begin
        wait_q <= wait_q + 1'b1;
      end
    end

    a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_q) <= NUM_VL - 1);
  end

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  a_r7_no_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |req) |-> |take);

endmodule

// File: rtl/vl_shaper.sv
module vl_shaper
  import vl_shaper_pkg::*;
#(
  parameter int NUM_VL       = 4,
  parameter int LEN_W        = 11,
  parameter int TICKS_PER_MS = 1000,
  parameter int ERR_W        = 8,
  parameter int ID_W         = (NUM_VL > 1) ? $clog2(NUM_VL) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         us_tick,
  input  logic [NUM_VL-1:0]            frm_rdy,
  input  logic [NUM_VL*LEN_W-1:0]      frm_len,
  input  logic [NUM_VL*LEN_W-1:0]      vl_lmax,
  input  logic [NUM_VL*BAG_CODE_W-1:0] vl_bag_code,
  input  logic                         tx_done,
  output logic [NUM_VL-1:0]            frm_pop,
  output logic                         frm_start,
  output logic [ID_W-1:0]              tx_vl,
  output logic [NUM_VL*ERR_W-1:0]      drop_cnt
);

  logic [NUM_VL-1:0] elig;
  logic [NUM_VL-1:0] drop;
  logic [NUM_VL-1:0] take;
  logic [ID_W-1:0]   pick_id;
  logic              busy_q;

  for (genvar v = 0; v < NUM_VL; v++) begin : g_reg
    vl_regulator #(
      .LEN_W       (LEN_W),
      .TICKS_PER_MS(TICKS_PER_MS),
      .ERR_W       (ERR_W)
    ) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .us_tick (us_tick),
      .rdy     (frm_rdy[v]),
      .len     (frm_len[v*LEN_W +: LEN_W]),
      .lmax    (vl_lmax[v*LEN_W +: LEN_W]),
      .bag_code(vl_bag_code[v*BAG_CODE_W +: BAG_CODE_W]),
      .take    (take[v]),
      .elig    (elig[v]),
      .drop    (drop[v]),
      .err_cnt (drop_cnt[v*ERR_W +: ERR_W])
    );
  end

  vl_rr_arb #(
    .NUM_VL(NUM_VL),
    .ID_W  (ID_W)
  ) i_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (!busy_q),
    .req    (elig),
    .take   (take),
    .pick_id(pick_id)
  );

  assign frm_pop = take | drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      frm_start <= 1'b0;
      tx_vl     <= '0;
    end else begin
      frm_start <= |take;
      if (|take) begin
        busy_q <= 1'b1;
        tx_vl  <= pick_id;
      end else if (tx_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (take == '0));

  a_r8_start_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> (frm_start && tx_vl == $past(pick_id)));

  a_r11_start_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !frm_start);

  a_r4_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (take & drop) == '0);

endmodule

// File: tb/test_vl_shaper.sv
module test_vl_shaper;
  localparam int NV  = 4;
  localparam int LW  = 11;
  localparam int TPM = 4;
  localparam int EW  = 3;
  localparam int IDW = 2;
  localparam int QD  = 16;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              us_tick;
  logic [NV-1:0]     frm_rdy;
  logic [NV*LW-1:0]  frm_len;
  logic [NV*LW-1:0]  vl_lmax;
  logic [NV*3-1:0]   vl_bag_code;
  logic              tx_done;
  logic [NV-1:0]     frm_pop;
  logic              frm_start;
  logic [IDW-1:0]    tx_vl;
  logic [NV*EW-1:0]  drop_cnt;

  vl_shaper #(.NUM_VL(NV), .LEN_W(LW), .TICKS_PER_MS(TPM), .ERR_W(EW)) i_vl_shaper (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .frm_rdy(frm_rdy), .frm_len(frm_len),
    .vl_lmax(vl_lmax), .vl_bag_code(vl_bag_code), .tx_done(tx_done), .frm_pop(frm_pop),
    .frm_start(frm_start), .tx_vl(tx_vl), .drop_cnt(drop_cnt)
  );

  int lmax_cfg [NV] = '{100, 200, 300, 1500};
  int code_cfg [NV] = '{0, 1, 2, 7};

  int    checks = 0, failures = 0, cyc = 0;
  string tag = "R1";
  int    q [NV][QD];
  int    qn [NV];
  int    rem [NV], errs [NV], since [NV], waitg [NV], last_start [NV], prev_start [NV];
  bit    pelig [NV];
  bit    pdrop [NV];
  bit    mbusy, tick_q, done_q;
  int    mptr, ptake;
  bit    finished = 1'b0;

  function automatic int gap_of(int v);
    return TPM * (2 ** code_cfg[v]);
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int v, int len);
    if (qn[v] < QD) begin
      q[v][qn[v]] = len;
      qn[v]++;
    end
  endtask

  task automatic drive_heads();
    for (int v = 0; v < NV; v++) begin
      frm_rdy[v] = qn[v] > 0;
      frm_len[v*LW +: LW] = (qn[v] > 0) ? LW'(q[v][0]) : '0;
    end
  endtask

  // Expected pops for the inputs now applied.
  task automatic predict();
    ptake = -1;
    for (int v = 0; v < NV; v++) begin
      pdrop[v] = (qn[v] > 0) && (q[v][0] > lmax_cfg[v]);
      pelig[v] = (qn[v] > 0) && !pdrop[v] && (rem[v] == 0);
    end
    if (!mbusy)
      for (int k = 0; k < NV; k++)
        if (ptake < 0 && pelig[(mptr + k) % NV]) ptake = (mptr + k) % NV;
    for (int v = 0; v < NV; v++)
      check(frm_pop[v] == (pdrop[v] || ptake == v), $sformatf("pop[%0d]", v),
            int'(frm_pop[v]), int'(pdrop[v] || ptake == v));
  endtask

  // Advance the reference by the edge that just passed and compare.
  task automatic model_edge();
    bit exp_start = (ptake >= 0);
    for (int v = 0; v < NV; v++) begin
      if (exp_start && pelig[v] && ptake != v) begin
        waitg[v]++;
        check(waitg[v] <= NV - 1, $sformatf("R9 wait of link %0d", v), waitg[v], NV - 1);
      end else if (ptake == v || !pelig[v]) begin
        waitg[v] = 0;
      end
      if (ptake == v) begin
        check(since[v] >= gap_of(v), $sformatf("R2 ticks before regrant of %0d", v),
              since[v], gap_of(v));
        since[v] = 0;
        prev_start[v] = last_start[v];
        last_start[v] = cyc;
        rem[v] = gap_of(v);
      end else begin
        if (tick_q && since[v] < (1 << 20)) since[v]++;
        if (tick_q && rem[v] > 0) rem[v]--;
      end
      if (pdrop[v] && errs[v] < EMAX) errs[v]++;
      if (ptake == v || pdrop[v]) begin
        for (int i = 0; i < QD - 1; i++) q[v][i] = q[v][i+1];
        qn[v]--;
      end
    end
    if (exp_start) begin
      mbusy = 1'b1;
      mptr = (ptake + 1) % NV;
    end else if (mbusy && done_q) begin
      mbusy = 1'b0;
    end
    check(frm_start == exp_start, "frm_start", int'(frm_start), int'(exp_start));
    if (exp_start) check(int'(tx_vl) == ptake, "tx_vl", int'(tx_vl), ptake);
    for (int v = 0; v < NV; v++)
      if (int'(drop_cnt[v*EW +: EW]) != errs[v])
        check(1'b0, $sformatf("drop_cnt[%0d]", v), int'(drop_cnt[v*EW +: EW]), errs[v]);
    ptake = -1;
    for (int v = 0; v < NV; v++) pdrop[v] = 1'b0;
  endtask

  task automatic cycle(bit tick, bit done);
    @(negedge clk);
    cyc++;
    model_edge();
    us_tick = tick;
    tx_done = done;
    tick_q  = tick;
    done_q  = done;
    drive_heads();
    #1;
    predict();
  endtask

  task automatic run(int n, bit tick, bit done);
    for (int i = 0; i < n; i++) cycle(tick, done);
  endtask

  initial begin
    void'($urandom(32'd20150301));
    rst_n = 1'b0; us_tick = 1'b0; tx_done = 1'b0; frm_rdy = '0; frm_len = '0;
    for (int v = 0; v < NV; v++) begin
      vl_lmax[v*LW +: LW] = LW'(lmax_cfg[v]);
      vl_bag_code[v*3 +: 3] = 3'(code_cfg[v]);
      qn[v] = 0; rem[v] = 0; errs[v] = 0; since[v] = 1 << 20; waitg[v] = 0;
      last_start[v] = 0; prev_start[v] = 0; pelig[v] = 0; pdrop[v] = 0;
    end
    mbusy = 0; mptr = 0; ptake = -1; tick_q = 0; done_q = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(frm_start == 1'b0, "R1 frm_start in reset", int'(frm_start), 0);
    check(drop_cnt == '0, "R1 drop_cnt in reset", int'(drop_cnt), 0);
    rst_n = 1'b1;
    push(2, 50);
    run(4, 1, 1);

    // R3: back-to-back on link 0 with immediate done
    tag = "R3";
    run(40, 1, 1);
    push(0, 60); push(0, 61);
    run(20, 1, 1);
    check(last_start[0] - prev_start[0] == gap_of(0) + 1, "R3 start spacing",
          last_start[0] - prev_start[0], gap_of(0) + 1);
    // R3: long transmission does not stretch the gap
    push(0, 62); push(0, 63);
    run(1, 1, 1);
    run(2, 1, 0);
    run(12, 1, 0);
    run(10, 1, 1);

    // R11: done pulses while idle
    tag = "R11";
    run(20, 1, 1);
    for (int i = 0; i < 6; i++) run(1, 0, i[0]);

    // R4 and R5: oversize discard then a valid frame on link 1
    tag = "R5";
    run(40, 1, 1);
    push(1, 201); push(1, 200);
    run(6, 1, 1);
    check(last_start[1] > 0, "R4 R5 valid frame granted", last_start[1], 1);

    // R10: saturation on link 0
    tag = "R10";
    run(20, 1, 1);
    for (int i = 0; i < 9; i++) push(0, 101 + i);
    run(12, 1, 1);
    check(int'(drop_cnt[0 +: EW]) == EMAX, "R10 saturated count", int'(drop_cnt[0 +: EW]), EMAX);

    // R6 and R7: simultaneous links, link 2 idle
    tag = "R6";
    run(600, 1, 1);
    push(0, 10); push(1, 20); push(3, 30);
    run(8, 1, 1);
    tag = "R7";
    push(3, 31); push(1, 21);
    run(600, 1, 1);

    // R2: the longest gap on link 3
    tag = "R2";
    push(3, 40); push(3, 41);
    run(530, 1, 1);
    check(last_start[3] - prev_start[3] == gap_of(3) + 1, "R2 longest gap",
          last_start[3] - prev_start[3], gap_of(3) + 1);

    // Random mix
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 3 == 0) begin
        int v = int'($urandom % NV);
        if ($urandom % 8 == 0) push(v, lmax_cfg[v] + 1 + int'($urandom % 40));
        else push(v, 1 + int'($urandom % lmax_cfg[v]));
      end
      cycle(($urandom % 4) != 0, ($urandom % 3) == 0);
    end
    run(20, 1, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule